// File: doc/BRIEF.md
# Program Counter Next-Address Unit

This block keeps the processor's 16-bit program counter and works out, on every clock, what the counter will hold next. A 2-bit select from the control sequencer picks one of four updates: keep the current value, advance by one instruction word (two bytes, since addressing is byte based), load a fixed entry address, or load a jump target produced by the ALU. When the entry-address load is selected, a single qualifier bit picks the interrupt entry address when it is high and the reset entry address when it is low.

Alongside the current address the block drives the current address plus two as a separate output, for use as a return address written into a register and as an operand the ALU can select. That output follows the register combinationally. All pins are plain control and data pins; no handshake is involved, because the counter takes a new value on every rising edge. The register has its own synchronous reset that places it at the reset entry address, so execution starts there after power-up.

Top module: `pc_next_unit`

## Requirements
- R1: While `rst` is high at a rising clock edge, `pc_now` becomes 16'hFD00 after that edge, whatever `pc_sel`, `vec_is_irq` and `jump_target` hold.
- R2: With `pc_sel` = 2'b00 (hold) at a rising edge, `pc_now` keeps its previous value.
- R3: With `pc_sel` = 2'b01 (step) at a rising edge, `pc_now` becomes its previous value plus 2, modulo 2^16 (16'hFFFE steps to 16'h0000).
- R4: With `pc_sel` = 2'b10 (vector) and `vec_is_irq` low at a rising edge, `pc_now` becomes 16'hFD00.
- R5: With `pc_sel` = 2'b10 (vector) and `vec_is_irq` high at a rising edge, `pc_now` becomes 16'hFE00.
- R6: With `pc_sel` = 2'b11 (jump) at a rising edge, `pc_now` becomes `jump_target` with bit 0 forced to 0.
- R7: `pc_plus2` always equals `pc_now` plus 2 modulo 2^16, with no clock of delay.
- R8: `vec_is_irq` has no effect on `pc_now` when `pc_sel` is not 2'b10.
- R9: `jump_target` has no effect on `pc_now` when `pc_sel` is not 2'b11.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high; loads the reset entry address |
| pc_sel | input | 2 | Update select: 0 hold, 1 step by 2, 2 entry address, 3 jump |
| vec_is_irq | input | 1 | Entry-address qualifier: 1 interrupt entry, 0 reset entry |
| jump_target | input | 16 | Jump address from the ALU; bit 0 is discarded |
| pc_now | output | 16 | Current program counter |
| pc_plus2 | output | 16 | Current program counter plus 2 |

## Verification
The hardest case to reach is the wrap of the step adder, because after reset the counter sits at 16'hFD00 and stepping alone would need hundreds of cycles to get to the top of the address space. The stimulus instead jumps to an odd address just below the top (16'hFFFF, which must land at 16'hFFFE), checks that the return-address output already reads zero there, then steps once across the boundary. Ignored inputs are covered by toggling the qualifier and the jump bus with arbitrary values during hold and step cycles and comparing the resulting counter with the model.

// File: rtl/pcu_pkg.sv
package pcu_pkg;
  typedef enum logic [1:0] {
    PC_HOLD   = 2'd0,
    PC_STEP   = 2'd1,
    PC_VECTOR = 2'd2,
    PC_JUMP   = 2'd3
  } pc_sel_e;
endpackage

// File: rtl/pcu_vector.sv
module pcu_vector #(
  parameter int ADDR_W = 16,
  parameter logic [ADDR_W-1:0] RESET_VEC = 16'hFD00,
  parameter logic [ADDR_W-1:0] IRQ_VEC = 16'hFE00
) (
  input  logic              use_irq,
  output logic [ADDR_W-1:0] entry_addr
);
  always_comb begin
    entry_addr = use_irq ? IRQ_VEC : RESET_VEC;
  end
endmodule

// File: rtl/pcu_incr.sv
module pcu_incr #(
  parameter int ADDR_W = 16,
  parameter int STEP = 2
) (
  input  logic [ADDR_W-1:0] cur,
  output logic [ADDR_W-1:0] bumped
);
  localparam logic [ADDR_W-1:0] STEP_V = ADDR_W'(STEP);
  assign bumped = cur + STEP_V;
endmodule

// File: rtl/pcu_next_mux.sv
module pcu_next_mux
  import pcu_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int ALIGN_BITS = 1
) (
  input  pc_sel_e           sel,
  input  logic [ADDR_W-1:0] cur,
  input  logic [ADDR_W-1:0] bumped,
  input  logic [ADDR_W-1:0] entry_addr,
  input  logic [ADDR_W-1:0] jump,
  output logic [ADDR_W-1:0] nxt
);
  logic [ADDR_W-1:0] jump_al;

  generate
    if (ALIGN_BITS == 0) begin : g_no_align
      assign jump_al = jump;
    end else begin : g_align
      assign jump_al = {jump[ADDR_W-1:ALIGN_BITS], {ALIGN_BITS{1'b0}}};
    end
  endgenerate

  always_comb begin
    unique case (sel)
      PC_HOLD:   nxt = cur;
      PC_STEP:   nxt = bumped;
      PC_VECTOR: nxt = entry_addr;
      PC_JUMP:   nxt = jump_al;
      default:   nxt = cur;
    endcase
  end
endmodule

// File: rtl/pcu_reg.sv
module pcu_reg #(
  parameter int ADDR_W = 16,
  parameter logic [ADDR_W-1:0] RESET_VEC = 16'hFD00
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] d,
  output logic [ADDR_W-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst) q <= RESET_VEC;
    else     q <= d;
  end
endmodule

// File: rtl/pc_next_unit.sv
module pc_next_unit
  import pcu_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int STEP = 2,
  parameter int ALIGN_BITS = 1,
  parameter logic [ADDR_W-1:0] RESET_VEC = 16'hFD00,
  parameter logic [ADDR_W-1:0] IRQ_VEC = 16'hFE00
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [1:0]        pc_sel,
  input  logic              vec_is_irq,
  input  logic [ADDR_W-1:0] jump_target,
  output logic [ADDR_W-1:0] pc_now,
  output logic [ADDR_W-1:0] pc_plus2
);
  localparam logic [ADDR_W-1:0] STEP_V = ADDR_W'(STEP);
  localparam logic [ADDR_W-1:0] JUMP_MASK = {ADDR_W{1'b1}} << ALIGN_BITS;

  pc_sel_e           sel;
  logic [ADDR_W-1:0] entry_addr;
  logic [ADDR_W-1:0] next_pc;

  assign sel = pc_sel_e'(pc_sel);

  pcu_vector #(.ADDR_W(ADDR_W), .RESET_VEC(RESET_VEC), .IRQ_VEC(IRQ_VEC)) u_vec (
    .use_irq   (vec_is_irq),
    .entry_addr(entry_addr)
  );

  pcu_incr #(.ADDR_W(ADDR_W), .STEP(STEP)) u_inc (
    .cur   (pc_now),
    .bumped(pc_plus2)
  );

  pcu_next_mux #(.ADDR_W(ADDR_W), .ALIGN_BITS(ALIGN_BITS)) u_mux (
    .sel       (sel),
    .cur       (pc_now),
    .bumped    (pc_plus2),
    .entry_addr(entry_addr),
    .jump      (jump_target),
    .nxt       (next_pc)
  );

  pcu_reg #(.ADDR_W(ADDR_W), .RESET_VEC(RESET_VEC)) u_reg (
    .clk(clk),
    .rst(rst),
    .d  (next_pc),
    .q  (pc_now)
  );

  assert_hold_R2: assert property (@(posedge clk) disable iff (rst)
    pc_sel == 2'd0 |=> $stable(pc_now));

  assert_step_R3: assert property (@(posedge clk) disable iff (rst)
    pc_sel == 2'd1 |=> pc_now == $past(pc_now) + STEP_V);

  assert_reset_vec_R4: assert property (@(posedge clk) disable iff (rst)
    (pc_sel == 2'd2 && !vec_is_irq) |=> pc_now == RESET_VEC);

  assert_irq_vec_R5: assert property (@(posedge clk) disable iff (rst)
    (pc_sel == 2'd2 && vec_is_irq) |=> pc_now == IRQ_VEC);

  assert_jump_R6: assert property (@(posedge clk) disable iff (rst)
    pc_sel == 2'd3 |=> pc_now == ($past(jump_target) & JUMP_MASK));

  assert_plus_gap_R7: assert property (@(posedge clk) disable iff (rst)
    (pc_plus2 - pc_now) == STEP_V);
endmodule

// File: tb/sim_pc_next_unit.sv
module sim_pc_next_unit;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [1:0]  pc_sel = 2'd0;
  logic        vec_is_irq = 1'b0;
  logic [15:0] jump_target = 16'h0;
  logic [15:0] pc_now;
  logic [15:0] pc_plus2;

  typedef struct {
    logic [15:0] pc;
    string       tag;
  } exp_t;

  exp_t        sb[$];
  int          checks = 0;
  int          errors = 0;
  logic [15:0] model_pc = 16'hFD00;
  bit          done = 1'b0;

  always #4 clk = ~clk;

  pc_next_unit u0 (
    .clk(clk), .rst(rst), .pc_sel(pc_sel), .vec_is_irq(vec_is_irq),
    .jump_target(jump_target), .pc_now(pc_now), .pc_plus2(pc_plus2)
  );

  task automatic drive(input logic r, input logic [1:0] s, input logic q,
                       input logic [15:0] jt, input string tag);
    exp_t e;
    @(negedge clk);
    rst = r; pc_sel = s; vec_is_irq = q; jump_target = jt;
    if (r) model_pc = 16'hFD00;
    else case (s)
      2'd0: model_pc = model_pc;
      2'd1: model_pc = model_pc + 16'd2;
      2'd2: model_pc = q ? 16'hFE00 : 16'hFD00;
      default: model_pc = {jt[15:1], 1'b0};
    endcase
    e.pc = model_pc; e.tag = tag;
    sb.push_back(e);
  endtask

  initial begin : monitor
    exp_t e;
    forever begin
      @(posedge clk); #1;
      if (sb.size() > 0) begin
        e = sb.pop_front();
        checks++;
        if (pc_now !== e.pc) begin
          errors++;
          $display("FAIL %s pc_now actual=%h expected=%h", e.tag, pc_now, e.pc);
        end
        checks++;
        if (pc_plus2 !== e.pc + 16'd2) begin
          errors++;
          $display("FAIL R7 pc_plus2 actual=%h expected=%h", pc_plus2, e.pc + 16'd2);
        end
      end
    end
  end

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks + 1);
      $finish;
    end
  end

  initial begin : stimulus
    drive(1'b1, 2'd3, 1'b1, 16'h1234, "R1");
    drive(1'b1, 2'd1, 1'b0, 16'h0000, "R1");
    drive(1'b0, 2'd0, 1'b1, 16'hABCD, "R2 R8 R9");
    drive(1'b0, 2'd1, 1'b1, 16'h5555, "R3 R8 R9");
    drive(1'b0, 2'd1, 1'b0, 16'hAAAA, "R3");
    drive(1'b0, 2'd0, 1'b0, 16'h0F0F, "R2 R9");
    drive(1'b0, 2'd2, 1'b1, 16'h7777, "R5 R9");
    drive(1'b0, 2'd0, 1'b0, 16'h3333, "R2 R8");
    drive(1'b0, 2'd2, 1'b0, 16'h4444, "R4 R9");
    drive(1'b0, 2'd3, 1'b1, 16'h1235, "R6 R8");
    drive(1'b0, 2'd3, 1'b0, 16'hFFFF, "R6");
    drive(1'b0, 2'd1, 1'b1, 16'h2468, "R3 R7 wrap");
    drive(1'b0, 2'd1, 1'b0, 16'h0001, "R3");
    for (int i = 0; i < 24; i++) begin
      logic [15:0] v = 16'(i * 16'h2F35 + 16'h0103);
      drive(1'b0, 2'(i % 4), v[3], v, "R2 R3 R4 R5 R6 mix");
    end
    drive(1'b0, 2'd2, 1'b1, 16'h0000, "R5");
    drive(1'b1, 2'd3, 1'b1, 16'hBEEF, "R1 mid-run");
    drive(1'b0, 2'd0, 1'b0, 16'h0000, "R2");
    @(negedge clk); rst = 1'b0; pc_sel = 2'd0;
    repeat (3) @(posedge clk);
    #2;
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule